// File: doc/BRIEF.md
# Multi-Channel Receive DMA Merge

This block funnels the receive streams of several peripherals into one 32-bit memory write port. Each peripheral channel offers a word with a valid flag and a size code. A round-robin arbiter picks one eligible channel per cycle and acknowledges it in that same cycle. The winner's ID, data and size are captured in a single pipeline register. In the next cycle that ID indexes a per-channel context table (pointer, bytes left, enable) to form the write address and to update the table. With no stall on the memory port, one write leaves the block every cycle.

Software sets up a channel with three writes on a small configuration port: the start pointer, the length in bytes, and a start command. Each accepted write advances the channel's pointer by the transfer size. It also lowers the channel's remaining count by the same amount. When the count runs out, the channel switches itself off and raises a one-cycle end-of-transfer pulse.

Top module: `rx_dma_merge`

## Requirements
- R1: `ch_ready` has at most one bit set in any cycle. A bit is set only for a channel whose `ch_valid` is high and which is enabled.
- R2: Arbitration is round-robin. After channel k is acknowledged, the next acknowledge goes to the first eligible channel in the order k+1, k+2, ... wrapping at NUM_CH. After reset the search starts at channel 1.
- R3: The cycle after an acknowledge, `mem_req` is high. In that cycle `mem_wdata` and `mem_size` carry the data and size code the channel offered in the acknowledge cycle.
- R4: While `mem_req` is high, `mem_addr` is the current pointer of the channel being written. A channel's first write goes to the pointer programmed for it.
- R5: Size codes on `ch_size` and `mem_size` are 2 bits per channel: 0 is 1 byte, 1 is 2 bytes, 2 and 3 are 4 bytes. Each accepted write advances that channel's pointer by this byte count.
- R6: With a channel continuously valid and no stall, `mem_req` is high in every cycle, giving one write per clock.
- R7: Each accepted write lowers the channel's remaining count by its byte count, clamped at zero. The write that brings the count to zero produces a one-cycle pulse on that channel's `eot` bit in the following cycle. The channel is then disabled and gets no further acknowledge.
- R8: While `mem_req` and `mem_stall` are both high, no channel is acknowledged. `mem_req`, `mem_wdata` and `mem_size` hold until the write is accepted.
- R9: The configuration port takes `cfg_sel` 0 for the pointer, 1 for the length in bytes and 2 for start; `cfg_we` qualifies it and `cfg_ch` selects the channel. Start enables the channel only if its length is non-zero. After reset no channel is enabled.
- R10: A channel is not acknowledged when its write already in the pipeline will use up its remaining bytes. The number of writes issued for a channel is therefore ceil(length / bytes per write).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_valid | input | NUM_CH | Per-channel data available |
| ch_data | input | NUM_CH*32 | Per-channel data word, channel i at bits 32*i+31:32*i |
| ch_size | input | NUM_CH*2 | Per-channel size code, channel i at bits 2*i+1:2*i |
| ch_ready | output | NUM_CH | One-hot acknowledge to the winning channel |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | clog2(NUM_CH) | Channel addressed by the configuration write |
| cfg_sel | input | 2 | 0 pointer, 1 length, 2 start |
| cfg_wdata | input | ADDR_W | Configuration write value |
| mem_req | output | 1 | Memory write request |
| mem_stall | input | 1 | Memory port cannot accept the request this cycle |
| mem_addr | output | ADDR_W | Memory write byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_size | output | 2 | Memory write size code |
| eot | output | NUM_CH | One-cycle end-of-transfer pulse per channel |

## Verification
The main stimulus is several thousand cycles in which each channel's valid, size code and data change at random every cycle. The memory stall is raised about a quarter of the time. Channels are reprogrammed with fresh random pointers and lengths as soon as they finish. This separates a fair rotation from a fixed-priority one, and it exposes wrong pointer steps for each size. It also catches an off-by-one in the final write, because lengths are often not a multiple of the size. A directed run with one channel always valid and never stalled tells a one-per-cycle pipeline apart from one that inserts bubbles. The reset-time check with all valids raised shows that an unstarted channel is never acknowledged.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;

    localparam int DATA_W = 32;

    localparam logic [1:0] CFG_PTR   = 2'd0;
    localparam logic [1:0] CFG_LEN   = 2'd1;
    localparam logic [1:0] CFG_START = 2'd2;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WALT = 2'd3
    } xfer_size_e;

    typedef struct packed {
        logic [1:0]        size;
        logic [DATA_W-1:0] data;
    } beat_t;

    function automatic logic [2:0] size_bytes(input logic [1:0] code);
        case (xfer_size_e'(code))
            SZ_BYTE: size_bytes = 3'd1;
            SZ_HALF: size_bytes = 3'd2;
            default: size_bytes = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/rxdma_rr_arb.sv
module rxdma_rr_arb #(
    parameter int NUM_CH = 4,
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] req,
    output logic [NUM_CH-1:0] gnt,
    output logic [CH_W-1:0]   gnt_id
);
    logic [CH_W-1:0] last_q;

    always_comb begin
        logic found;
        gnt    = '0;
        gnt_id = '0;
        found  = 1'b0;
        for (int off = 1; off <= NUM_CH; off++) begin
            int idx;
            idx = (int'(last_q) + off) % NUM_CH;
            if (!found && req[idx]) begin
                gnt[idx] = 1'b1;
                gnt_id   = CH_W'(idx);
                found    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            last_q <= '0;
        else if (|gnt)
            last_q <= gnt_id;
    end
endmodule

// File: rtl/rxdma_ctx.sv
module rxdma_ctx
    import rxdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_hit,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              upd,
    input  logic [2:0]        upd_bytes,
    output logic [ADDR_W-1:0] ptr,
    output logic [LEN_W-1:0]  rem,
    output logic              en,
    output logic              eot
);
    logic [LEN_W-1:0] step;
    assign step = LEN_W'(upd_bytes);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
            rem <= '0;
            en  <= 1'b0;
            eot <= 1'b0;
        end else begin
            eot <= 1'b0;
            if (cfg_hit) begin
                case (cfg_sel)
                    CFG_PTR:   ptr <= cfg_wdata;
                    CFG_LEN:   rem <= cfg_wdata[LEN_W-1:0];
                    CFG_START: en  <= (rem != '0);
                    default:   ;
                endcase
            end else if (upd) begin
                ptr <= ptr + ADDR_W'(upd_bytes);
                if (rem <= step) begin
                    rem <= '0;
                    en  <= 1'b0;
                    eot <= 1'b1;
                end else begin
                    rem <= rem - step;
                end
            end
        end
    end
endmodule

// File: rtl/rx_dma_merge.sv
module rx_dma_merge
    import rxdma_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_CH-1:0]        ch_valid,
    input  logic [NUM_CH*DATA_W-1:0] ch_data,
    input  logic [NUM_CH*2-1:0]      ch_size,
    output logic [NUM_CH-1:0]        ch_ready,
    input  logic                     cfg_we,
    input  logic [CH_W-1:0]          cfg_ch,
    input  logic [1:0]               cfg_sel,
    input  logic [ADDR_W-1:0]        cfg_wdata,
    output logic                     mem_req,
    input  logic                     mem_stall,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic [DATA_W-1:0]        mem_wdata,
    output logic [1:0]               mem_size,
    output logic [NUM_CH-1:0]        eot
);
    logic [ADDR_W-1:0] ptr_q [NUM_CH];
    logic [LEN_W-1:0]  rem_q [NUM_CH];
    logic [NUM_CH-1:0] ch_en;
    logic [NUM_CH-1:0] elig;
    logic [NUM_CH-1:0] gnt;
    logic [CH_W-1:0]   gnt_id;

    logic              s1_vld;
    logic [CH_W-1:0]   s1_ch;
    beat_t             s1_beat;
    logic              advance;
    logic              accept;
    logic [2:0]        s1_bytes;

    assign advance  = !s1_vld || !mem_stall;
    assign accept   = s1_vld && !mem_stall;
    assign s1_bytes = size_bytes(s1_beat.size);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic in_flight;
        logic room;
        assign in_flight = s1_vld && (s1_ch == CH_W'(i));
        assign room = in_flight ? (rem_q[i] > LEN_W'(s1_bytes)) : (rem_q[i] != '0);
        assign elig[i] = ch_valid[i] && ch_en[i] && room && advance;

        rxdma_ctx #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) ctx_i (
            .clk       (clk),
            .rst       (rst),
            .cfg_hit   (cfg_we && (cfg_ch == CH_W'(i))),
            .cfg_sel   (cfg_sel),
            .cfg_wdata (cfg_wdata),
            .upd       (accept && in_flight),
            .upd_bytes (s1_bytes),
            .ptr       (ptr_q[i]),
            .rem       (rem_q[i]),
            .en        (ch_en[i]),
            .eot       (eot[i])
        );
    end

    rxdma_rr_arb #(.NUM_CH(NUM_CH)) arb_i (
        .clk    (clk),
        .rst    (rst),
        .req    (elig),
        .gnt    (gnt),
        .gnt_id (gnt_id)
    );

    assign ch_ready = gnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_vld  <= 1'b0;
            s1_ch   <= '0;
            s1_beat <= '0;
        end else if (advance) begin
            s1_vld       <= |gnt;
            s1_ch        <= gnt_id;
            s1_beat.data <= ch_data[gnt_id*DATA_W +: DATA_W];
            s1_beat.size <= ch_size[gnt_id*2 +: 2];
        end
    end

    assign mem_req   = s1_vld;
    assign mem_addr  = ptr_q[s1_ch];
    assign mem_wdata = s1_beat.data;
    assign mem_size  = s1_beat.size;
endmodule

// File: rtl/rx_dma_merge_chk.sv
module rx_dma_merge_chk #(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [NUM_CH-1:0] ch_valid,
    input logic [NUM_CH-1:0] ch_ready,
    input logic [NUM_CH-1:0] ch_en,
    input logic              mem_req,
    input logic              mem_stall,
    input logic [31:0]       mem_wdata,
    input logic [1:0]        mem_size,
    input logic [NUM_CH-1:0] eot
);
    p_grant_onehot_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ch_ready));

    p_grant_valid_r1: assert property (@(posedge clk) disable iff (rst)
        (ch_ready & ~ch_valid) == '0);

    p_grant_enabled_r9: assert property (@(posedge clk) disable iff (rst)
        (ch_ready & ~ch_en) == '0);

    p_req_follows_grant_r3: assert property (@(posedge clk) disable iff (rst)
        (|ch_ready) |=> mem_req);

    p_stall_no_grant_r8: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_stall) |-> (ch_ready == '0));

    p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_stall) |=> (mem_req && $stable(mem_wdata) && $stable(mem_size)));

    p_eot_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        (|eot) |=> ((eot & $past(eot)) == '0));
endmodule

bind rx_dma_merge rx_dma_merge_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .ch_valid  (ch_valid),
    .ch_ready  (ch_ready),
    .ch_en     (ch_en),
    .mem_req   (mem_req),
    .mem_stall (mem_stall),
    .mem_wdata (mem_wdata),
    .mem_size  (mem_size),
    .eot       (eot)
);

// File: tb/rx_dma_merge_tb_top.sv
module rx_dma_merge_tb_top;
    localparam int N  = 4;
    localparam int CW = 2;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [N-1:0]    ch_valid = '0;
    logic [N*32-1:0] ch_data = '0;
    logic [N*2-1:0]  ch_size = '0;
    logic [N-1:0]    ch_ready;
    logic            cfg_we = 1'b0;
    logic [CW-1:0]   cfg_ch = '0;
    logic [1:0]      cfg_sel = '0;
    logic [31:0]     cfg_wdata = '0;
    logic            mem_req;
    logic            mem_stall = 1'b0;
    logic [31:0]     mem_addr;
    logic [31:0]     mem_wdata;
    logic [1:0]      mem_size;
    logic [N-1:0]    eot;

    always #10 clk = ~clk;

    rx_dma_merge #(.NUM_CH(N), .ADDR_W(32), .LEN_W(16)) dut_i (
        .clk(clk), .rst(rst), .ch_valid(ch_valid), .ch_data(ch_data),
        .ch_size(ch_size), .ch_ready(ch_ready), .cfg_we(cfg_we),
        .cfg_ch(cfg_ch), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .mem_req(mem_req), .mem_stall(mem_stall), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_size(mem_size), .eot(eot)
    );

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    // reference state
    bit        m_en  [N];
    int        m_ptr [N];
    int        m_rem [N];
    int        m_last = 0;
    bit        m_vld = 0;
    int        m_ch = 0;
    logic [31:0] m_data = '0;
    int        m_size = 0;
    logic [N-1:0] m_eot = '0;

    function automatic int nbytes(input int code);
        return (code == 0) ? 1 : (code == 1) ? 2 : 4;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // inputs already driven for this cycle; compare and advance the reference
    task automatic step();
        logic [N-1:0] eg;
        int gid;
        bit adv;
        #1;
        chk(mem_req === m_vld, "R3 mem_req", 32'(mem_req), 32'(m_vld));
        if (m_vld) begin
            chk(mem_addr === m_ptr[m_ch], "R4 R5 mem_addr", mem_addr, m_ptr[m_ch]);
            chk(mem_wdata === m_data, "R3 mem_wdata", mem_wdata, m_data);
            chk(mem_size === 2'(m_size), "R3 mem_size", 32'(mem_size), m_size);
        end
        chk(eot === m_eot, "R7 eot", 32'(eot), 32'(m_eot));
        adv = !m_vld || !mem_stall;
        eg = '0;
        gid = 0;
        for (int off = 1; off <= N; off++) begin
            int c;
            int left;
            c = (m_last + off) % N;
            left = m_rem[c];
            if (m_vld && m_ch == c) left = left - nbytes(m_size);
            if (eg == '0 && adv && ch_valid[c] && m_en[c] && left > 0) begin
                eg[c] = 1'b1;
                gid = c;
            end
        end
        chk(ch_ready === eg, "R1 R2 R8 R10 ch_ready", 32'(ch_ready), 32'(eg));
        m_eot = '0;
        for (int c = 0; c < N; c++) begin
            if (cfg_we && cfg_ch == c) begin
                if (cfg_sel == 0) m_ptr[c] = cfg_wdata;
                else if (cfg_sel == 1) m_rem[c] = cfg_wdata[15:0];
                else if (cfg_sel == 2) m_en[c] = (m_rem[c] != 0);
            end else if (m_vld && !mem_stall && m_ch == c) begin
                m_ptr[c] = m_ptr[c] + nbytes(m_size);
                if (m_rem[c] <= nbytes(m_size)) begin
                    m_rem[c] = 0;
                    m_en[c] = 0;
                    m_eot[c] = 1'b1;
                end else begin
                    m_rem[c] = m_rem[c] - nbytes(m_size);
                end
            end
        end
        if (adv) begin
            m_vld = (eg != '0);
            m_ch = gid;
            m_data = ch_data[gid*32 +: 32];
            m_size = int'(ch_size[gid*2 +: 2]);
        end
        if (eg != '0) m_last = gid;
    endtask

    task automatic cfg(input int c, input int sel, input int val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ch = CW'(c); cfg_sel = 2'(sel); cfg_wdata = val;
        step();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL R6 watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        int prog_c;
        int prog_st;
        int reqs;
        for (int c = 0; c < N; c++) begin
            m_en[c] = 0; m_ptr[c] = 0; m_rem[c] = 0;
        end
        // reset: no channel started, all valid
        ch_valid = '1;
        repeat (3) @(negedge clk);
        chk(mem_req === 1'b0, "R9 reset mem_req", 32'(mem_req), 0);
        chk(eot === '0, "R9 reset eot", 32'(eot), 0);
        @(negedge clk);
        rst = 1'b0;
        step();
        chk(ch_ready === '0, "R9 unstarted ch_ready", 32'(ch_ready), 0);

        // directed throughput: channel 2, 32 bytes of 4-byte writes
        ch_valid = '0;
        cfg(2, 0, 32'h1000);
        cfg(2, 1, 32);
        cfg(2, 2, 0);
        @(negedge clk);
        cfg_we = 1'b0;
        ch_valid = 4'b0100;
        ch_size = '1;
        reqs = 0;
        for (int k = 0; k < 12; k++) begin
            if (k > 0) @(negedge clk);
            ch_data = {4{32'(k) * 32'h01010101}};
            step();
            if (mem_req) reqs++;
        end
        chk(reqs == 8, "R6 R10 write count", reqs, 8);

        // random sweep with reprogramming
        prog_c = -1;
        prog_st = 0;
        for (int cyc = 0; cyc < 6000; cyc++) begin
            @(negedge clk);
            cfg_we = 1'b0;
            if (prog_c < 0) begin
                for (int c = 0; c < N; c++)
                    if (prog_c < 0 && !m_en[c] && !(m_vld && m_ch == c) && $urandom_range(3) == 0)
                        prog_c = c;
                prog_st = 0;
            end
            if (prog_c >= 0) begin
                cfg_we = 1'b1;
                cfg_ch = CW'(prog_c);
                cfg_sel = 2'(prog_st);
                cfg_wdata = (prog_st == 0) ? $urandom : $urandom_range(40, 1);
                prog_st++;
                if (prog_st == 3) prog_c = -1;
            end
            for (int c = 0; c < N; c++) begin
                ch_valid[c] = ($urandom_range(3) != 0);
                ch_size[c*2 +: 2] = 2'($urandom_range(3));
                ch_data[c*32 +: 32] = $urandom;
            end
            mem_stall = ($urandom_range(3) == 0);
            step();
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule